// File: doc/BRIEF.md
# SSI Absolute Position Transmitter

This block is the encoder end of a synchronous serial link. An external master drives a clock line that idles high. On the first falling edge of a read, the block captures a parallel absolute position word together with a health flag. On each later rising edge it presents one frame bit on the data line, most significant position bit first, so the master can sample on its falling edges.

The frame is left aligned. The position bits come first. An optional health bit and an optional even-parity bit may follow them, and each is enabled by a parameter. If the master sends more clocks than the frame holds, the extra bits are zeros.

Once the master stops clocking, the line stays low for a monoflop interval that is counted in system clocks. The line then returns high, and only after that can a new read start. The master clock is asynchronous to the system clock and is synchronised before its edges are detected.

Top module: `ssi_tx_top`

## Requirements
- R1: After reset, and at any time no read is in progress, the data line is high.
- R2: The position word and the health flag are captured on the first falling SSI clock edge of a read. Later changes on `pos_i` and `pos_ok_i` do not alter the frame being sent.
- R3: Each rising SSI clock edge of a read presents the next frame bit. The first rising edge presents position bit POS_W-1, and the last position bit presented is bit 0.
- R4: With HAS_ERR set, the bit after position bit 0 equals `pos_ok_i` as captured: 1 means normal and 0 means fault.
- R5: With HAS_PAR set, the bit after the health bit is the XOR of all captured position bits, which makes the count of ones over position and parity even.
- R6: Every rising edge past the end of the frame presents a 0.
- R7: After the last SSI clock edge the line stays low. It returns high MONO_CYC system cycles (plus the synchroniser latency) after that edge, provided no further edge arrives.
- R8: SSI clock edges during the monoflop interval do not start a new read. The line stays low and the interval restarts from the latest edge.
- R9: The block keeps up with SSI clock half-periods as short as 4 system cycles, which at 125 MHz covers 2 Mbit/s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ssi_clk_i | input | 1 | Master clock, asynchronous, idles high |
| pos_i | input | POS_W | Absolute position word |
| pos_ok_i | input | 1 | Health flag, 1 = normal, 0 = fault |
| ssi_data_o | output | 1 | Serial data line to the master |

## Verification
The data line changes three system cycles after an SSI clock level change: two synchroniser stages, then the output register. The bench drives the clock at a falling system edge and samples a full half-period later, at least four cycles on, just before it drives the next level change. The monoflop release comes MONO_CYC plus about three cycles after the last edge. The bench therefore checks the line low 20 cycles before that point and high 20 cycles after it, which keeps both samples clear of the exact transition cycle.

// File: rtl/ssi_tx_pkg.sv
package ssi_tx_pkg;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } ssi_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } ssi_edge_t;

    function automatic int frame_bits(int pw, bit has_err, bit has_par);
        return pw + (has_err ? 1 : 0) + (has_par ? 1 : 0);
    endfunction

    function automatic int cnt_bits(int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/ssi_tx_sync.sv
module ssi_tx_sync #(
    parameter int STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ssi_clk_i,
    output ssi_tx_pkg::ssi_edge_t edge_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], ssi_clk_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    always_comb begin
        edge_o.fall = prev_q & ~chain_q[STAGES-1];
        edge_o.rise = ~prev_q & chain_q[STAGES-1];
    end
endmodule

// File: rtl/ssi_tx_frame.sv
module ssi_tx_frame #(
    parameter int POS_W   = 16,
    parameter bit HAS_ERR = 1'b1,
    parameter bit HAS_PAR = 1'b1,
    parameter int FW      = 18
) (
    input  logic [POS_W-1:0] pos_i,
    input  logic             ok_i,
    output logic [FW-1:0]    word_o
);
    logic par_s;
    assign par_s = ^pos_i;

    generate
        if (HAS_ERR && HAS_PAR) begin : g_err_par
            assign word_o = {pos_i, ok_i, par_s};
        end else if (HAS_ERR) begin : g_err
            assign word_o = {pos_i, ok_i};
        end else if (HAS_PAR) begin : g_par
            logic unused_ok;
            assign unused_ok = ok_i;
            assign word_o = {pos_i, par_s};
        end else begin : g_plain
            logic unused_ok;
            assign unused_ok = ok_i ^ par_s;
            assign word_o = pos_i;
        end
    endgenerate
endmodule

// File: rtl/ssi_tx_mono.sv
module ssi_tx_mono #(
    parameter int MONO_CYC = 2500,
    parameter int CW       = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic restart_i,
    output logic expire_o
);
    logic [CW-1:0] cnt_q;

    assign expire_o = run_i && !restart_i && (cnt_q == CW'(MONO_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !run_i || restart_i) begin
            cnt_q <= '0;
        end else if (!expire_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ssi_tx_top.sv
module ssi_tx_top #(
    parameter int POS_W       = 16,
    parameter bit HAS_ERR     = 1'b1,
    parameter bit HAS_PAR     = 1'b1,
    parameter int MONO_CYC    = 2500,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ssi_clk_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic             pos_ok_i,
    output logic             ssi_data_o
);
    import ssi_tx_pkg::*;

    localparam int FW = frame_bits(POS_W, HAS_ERR, HAS_PAR);
    localparam int CW = cnt_bits(MONO_CYC);

    ssi_edge_t     edge_s;
    logic          rise_s, fall_s, expire_s;
    logic [FW-1:0] word_s;
    logic [FW-1:0] shreg_q;
    ssi_state_e    state_q;
    logic          data_q;

    assign rise_s = edge_s.rise;
    assign fall_s = edge_s.fall;

    ssi_tx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .ssi_clk_i(ssi_clk_i), .edge_o(edge_s)
    );

    ssi_tx_frame #(.POS_W(POS_W), .HAS_ERR(HAS_ERR), .HAS_PAR(HAS_PAR), .FW(FW)) frame_i (
        .pos_i(pos_i), .ok_i(pos_ok_i), .word_o(word_s)
    );

    ssi_tx_mono #(.MONO_CYC(MONO_CYC), .CW(CW)) mono_i (
        .clk(clk), .rst(rst),
        .run_i(state_q == ST_ACTIVE),
        .restart_i(rise_s | fall_s),
        .expire_o(expire_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            shreg_q <= '0;
            data_q  <= 1'b1;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (fall_s) begin
                        shreg_q <= word_s;
                        state_q <= ST_ACTIVE;
                    end
                end
                ST_ACTIVE: begin
                    if (rise_s) begin
                        data_q  <= shreg_q[FW-1];
                        shreg_q <= {shreg_q[FW-2:0], 1'b0};
                    end else if (expire_s) begin
                        state_q <= ST_IDLE;
                        data_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ssi_data_o = data_q;
endmodule

// File: rtl/ssi_tx_chk.sv
module ssi_tx_chk #(
    parameter int FW = 18
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   ssi_data_o,
    input ssi_tx_pkg::ssi_state_e state_q,
    input logic                   rise_s,
    input logic                   fall_s,
    input logic                   expire_s,
    input logic [FW-1:0]          shreg_q,
    input logic [FW-1:0]          word_s
);
    import ssi_tx_pkg::*;

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> ssi_data_o);

    // R2
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && fall_s) |=> (state_q == ST_ACTIVE && shreg_q == $past(word_s)));

    // R3
    shift_out_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACTIVE && rise_s) |=> (ssi_data_o == $past(shreg_q[FW-1])));

    // R6
    zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACTIVE && rise_s) |=> (shreg_q[0] == 1'b0));

    // R7
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACTIVE && expire_s) |=> (state_q == ST_IDLE && ssi_data_o));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACTIVE && !rise_s && !expire_s) |=> ($stable(ssi_data_o) && state_q == ST_ACTIVE));
endmodule

bind ssi_tx_top ssi_tx_chk #(.FW(FW)) chk_i (
    .clk(clk), .rst(rst), .ssi_data_o(ssi_data_o), .state_q(state_q),
    .rise_s(rise_s), .fall_s(fall_s), .expire_s(expire_s),
    .shreg_q(shreg_q), .word_s(word_s)
);

// File: tb/ssi_tx_top_tb_top.sv
module ssi_tx_top_tb_top;
    localparam int POS_W = 12;
    localparam int MONO  = 200;
    localparam int FW    = POS_W + 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ssi_clk = 1'b1;
    logic [POS_W-1:0] pos = '0;
    logic             pos_ok = 1'b1;
    logic             data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ssi_tx_top #(.POS_W(POS_W), .HAS_ERR(1'b1), .HAS_PAR(1'b1), .MONO_CYC(MONO)) dut_i (
        .clk(clk), .rst(rst), .ssi_clk_i(ssi_clk), .pos_i(pos),
        .pos_ok_i(pos_ok), .ssi_data_o(data)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000 && !done) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%b expected=%b at cycle %0d", req, act, exp, cycles);
        end
    endtask

    function automatic logic exp_bit(input logic [POS_W-1:0] p, input logic ok, input int i);
        if (i < POS_W)  return p[POS_W-1-i];
        if (i == POS_W) return ok;
        if (i == POS_W + 1) return ^p;
        return 1'b0;
    endfunction

    function automatic string req_of(input int i, input bit scr, input int half);
        string s;
        if (i < POS_W)           s = "R3";
        else if (i == POS_W)     s = "R4";
        else if (i == POS_W + 1) s = "R5";
        else                     s = "R6";
        if (scr && i < FW) s = {s, " R2"};
        if (half == 4)     s = {s, " R9"};
        return s;
    endfunction

    task automatic run_frame(input logic [POS_W-1:0] p, input logic ok, input int nclk,
                             input int half, input bit scr, input bit poke);
        pos = p;
        pos_ok = ok;
        wait_cyc(2);
        ssi_clk = 1'b0;
        wait_cyc(half);
        if (scr) begin
            pos = ~p;
            pos_ok = ~ok;
        end
        for (int i = 0; i < nclk; i++) begin
            ssi_clk = 1'b1;
            wait_cyc(half);
            check(req_of(i, scr, half), data, exp_bit(p, ok, i));
            ssi_clk = 1'b0;
            wait_cyc(half);
        end
        ssi_clk = 1'b1;
        wait_cyc(half);
        check("R7 low after last clock", data, 1'b0);
        if (poke) begin
            wait_cyc(100);
            ssi_clk = 1'b0;
            wait_cyc(4);
            check("R8 fall in monoflop", data, 1'b0);
            ssi_clk = 1'b1;
            wait_cyc(4);
            check("R8 rise in monoflop", data, 1'b0);
            wait_cyc(MONO - 24);
            check("R8 interval restarted", data, 1'b0);
        end else begin
            wait_cyc(MONO - 20 - half);
            check("R7 still low before timeout", data, 1'b0);
        end
        wait_cyc(40);
        check("R7 R1 high after timeout", data, 1'b1);
    endtask

    initial begin
        void'($urandom(32'd4242));
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(3);
        check("R1 reset state", data, 1'b1);
        wait_cyc(20);
        check("R1 idle stays high", data, 1'b1);

        run_frame(12'hFFF, 1'b1, FW, 8, 1'b0, 1'b0);
        run_frame(12'h001, 1'b0, FW + 6, 4, 1'b0, 1'b0);
        run_frame(12'hA5A, 1'b1, FW + 2, 6, 1'b1, 1'b0);
        run_frame(12'h800, 1'b0, FW, 5, 1'b0, 1'b1);

        for (int k = 0; k < 26; k++) begin
            run_frame(POS_W'($urandom), 1'($urandom), FW + int'($urandom % 6),
                      4 + int'($urandom % 8), 1'($urandom), ($urandom % 4) == 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule